// File: doc/BRIEF.md
# TDM Time-Slot Channel Gate

This block picks out one programmable time slot from a frame-synchronous TDM bit stream, with a separate choice for the transmit side and the receive side. Every master clock cycle carries one bit. A single-cycle frame sync pulse, which recurs at 8 kHz, marks bit position zero. The block counts bit positions from that pulse. It opens a transmit window and a receive window, each at its own position and with its own width.

The start of each window is the slot number (0 to 63) times 8 bits, plus a shared bit offset of 0 to 7. A capacity field of N opens the window for N+1 bits. The outputs drive an HDLC serializer and deserializer: a transmit-enable strobe, a receive-enable strobe, and an active-low transmit-slot indicator that can be switched on or off. All outputs are registered. The strobe for a bit position appears in the cycle after the clock edge at which that position is counted.

Top module: `tdm_slot_gate`

## Requirements
- R1: The bit position is 0 in the cycle in which `fsync` is sampled high. It then rises by one per clock and holds at 512 (outside every window) until the next sync.
- R2: `tx_en` is high for a bit position p exactly when p >= tx_slot*8 + bit_ofs, and p is still inside the width given by R3.
- R3: The width in bits of a window is its capacity field plus one, so field 0 gives 1 bit and field 255 gives 256 bits.
- R4: `rx_en` follows the same rules using `rx_slot` and `rx_cap`, independently of the transmit settings.
- R5: While `ind_en` is high, `tx_ind_n` is low exactly during the transmit window and high otherwise.
- R6: While `ind_en` is low, `tx_ind_n` stays high.
- R7: No window covers bit positions 512 and above; a window reaching past position 511 is cut off there.
- R8: A sync that arrives before the frame ends restarts the count at 0 at once, and any open window closes unless it also covers position 0.
- R9: After reset, and until the first sync, `tx_en` and `rx_en` are low and `tx_ind_n` is high.
- R10: All outputs appear one clock after the edge at which their bit position is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync pulse, marks bit position 0 |
| tx_slot | input | 6 | Transmit slot number |
| tx_cap | input | 8 | Transmit capacity, width minus one |
| rx_slot | input | 6 | Receive slot number |
| rx_cap | input | 8 | Receive capacity, width minus one |
| bit_ofs | input | 3 | Bit offset added to both window starts |
| ind_en | input | 1 | Enables the active-low slot indicator |
| tx_en | output | 1 | Transmit window strobe |
| rx_en | output | 1 | Receive window strobe |
| tx_ind_n | output | 1 | Active-low transmit slot indicator |

## Verification
Two functions can fall in the same cycle: a sync that restarts the frame and a window that is open at that moment. The bench provokes this by issuing a new sync partway through a wide transmit window. It then checks that the strobe and the indicator drop in the very next output cycle and that the next frame starts cleanly. A second coincidence is truncation: the last slot is paired with the widest capacity, and the bench checks that the window closes exactly after position 511 while the counter holds at the frame end.

// File: rtl/tdm_gate_pkg.sv
package tdm_gate_pkg;
  localparam int DEF_FRAME_BITS = 512;
  localparam int DEF_SLOT_BITS  = 8;
  localparam int DEF_SLOT_W     = 6;
  localparam int DEF_CAP_W      = 8;
  localparam int DEF_OFS_W      = 3;
  localparam int NUM_DIRS       = 2;

  typedef enum int {DIR_TX = 0, DIR_RX = 1} dir_e;
endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter #(
  parameter int FRAME_BITS = 512,
  parameter int PW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] END_POS = PW'(FRAME_BITS);

  logic [PW-1:0] cnt_q;

  // Position of the bit counted at this edge; saturates at frame end.
  always_comb begin
    if (fsync)                pos = '0;
    else if (cnt_q == END_POS) pos = END_POS;
    else                      pos = cnt_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= END_POS;
    else     cnt_q <= pos;
  end

  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(fsync && !rst) |-> cnt_q == '0); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!fsync && cnt_q < END_POS) |=> cnt_q == $past(cnt_q) + PW'(1)); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fsync && cnt_q == END_POS) |=> cnt_q == END_POS); // R7
endmodule

// File: rtl/tdm_slot_window.sv
module tdm_slot_window #(
  parameter int FRAME_BITS = 512,
  parameter int SLOT_BITS  = 8,
  parameter int SLOT_W     = 6,
  parameter int CAP_W      = 8,
  parameter int OFS_W      = 3,
  parameter int PW         = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     pos,
  input  logic [SLOT_W-1:0] slot,
  input  logic [CAP_W-1:0]  cap,
  input  logic [OFS_W-1:0]  ofs,
  output logic              hit,
  output logic              en_q
);
  localparam logic [PW-1:0] END_POS = PW'(FRAME_BITS);

  logic [PW-1:0] start;
  logic [PW-1:0] stop;

  always_comb begin
    start = PW'(slot) * PW'(SLOT_BITS) + PW'(ofs);
    stop  = start + PW'(cap) + PW'(1);
    hit   = (pos >= start) && (pos < stop) && (pos < END_POS);
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= hit;
  end

  AST_WIN_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && pos < start) |-> !en_q); // R2

  AST_WIN_PAST_FRAME: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && pos >= END_POS) |-> !en_q); // R7

  AST_WIN_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && pos >= stop) |-> !en_q); // R3
endmodule

// File: rtl/tdm_slot_gate.sv
module tdm_slot_gate
  import tdm_gate_pkg::*;
#(
  parameter int FRAME_BITS = DEF_FRAME_BITS,
  parameter int SLOT_BITS  = DEF_SLOT_BITS,
  parameter int SLOT_W     = DEF_SLOT_W,
  parameter int CAP_W      = DEF_CAP_W,
  parameter int OFS_W      = DEF_OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [CAP_W-1:0]  tx_cap,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [CAP_W-1:0]  rx_cap,
  input  logic [OFS_W-1:0]  bit_ofs,
  input  logic              ind_en,
  output logic              tx_en,
  output logic              rx_en,
  output logic              tx_ind_n
);
  localparam int PW = $clog2(FRAME_BITS + (1 << CAP_W) + 1);

  logic [PW-1:0]                  pos;
  logic [NUM_DIRS-1:0][SLOT_W-1:0] slot_a;
  logic [NUM_DIRS-1:0][CAP_W-1:0]  cap_a;
  logic [NUM_DIRS-1:0]             hit_a;
  logic [NUM_DIRS-1:0]             en_a;
  logic                            ind_n_q;

  assign slot_a[DIR_TX] = tx_slot;
  assign slot_a[DIR_RX] = rx_slot;
  assign cap_a[DIR_TX]  = tx_cap;
  assign cap_a[DIR_RX]  = rx_cap;

  tdm_bit_counter #(.FRAME_BITS(FRAME_BITS), .PW(PW)) cnt_i (
    .clk(clk), .rst(rst), .fsync(fsync), .pos(pos)
  );

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    tdm_slot_window #(
      .FRAME_BITS(FRAME_BITS), .SLOT_BITS(SLOT_BITS), .SLOT_W(SLOT_W),
      .CAP_W(CAP_W), .OFS_W(OFS_W), .PW(PW)
    ) win_i (
      .clk(clk), .rst(rst), .pos(pos), .slot(slot_a[d]), .cap(cap_a[d]),
      .ofs(bit_ofs), .hit(hit_a[d]), .en_q(en_a[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ind_n_q <= 1'b1;
    else     ind_n_q <= ~(ind_en & hit_a[DIR_TX]);
  end

  assign tx_en    = en_a[DIR_TX];
  assign rx_en    = en_a[DIR_RX];
  assign tx_ind_n = ind_n_q;

  AST_IND_TRACKS_TX: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ind_en) |-> (tx_ind_n == !tx_en)); // R5

  AST_IND_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !ind_en) |-> tx_ind_n); // R6

  AST_SYNC_CLOSES: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && fsync && tx_slot != '0) |-> !tx_en); // R8
endmodule

// File: tb/tdm_slot_gate_tb_top.sv
module tdm_slot_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b0;
  logic [5:0] tx_slot = '0;
  logic [7:0] tx_cap = '0;
  logic [5:0] rx_slot = '0;
  logic [7:0] rx_cap = '0;
  logic [2:0] bit_ofs = '0;
  logic       ind_en = 1'b0;
  logic       tx_en, rx_en, tx_ind_n;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  tdm_slot_gate dut_i (
    .clk(clk), .rst(rst), .fsync(fsync), .tx_slot(tx_slot), .tx_cap(tx_cap),
    .rx_slot(rx_slot), .rx_cap(rx_cap), .bit_ofs(bit_ofs), .ind_en(ind_en),
    .tx_en(tx_en), .rx_en(rx_en), .tx_ind_n(tx_ind_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_win(input int p, input int slot, input int cap, input int ofs);
    int s = slot * 8 + ofs;
    return (p >= s) && (p < s + cap + 1) && (p < 512);
  endfunction

  // Sync, then compare every output against the model for len positions.
  task automatic run_frame(input int ts, input int tc, input int rs, input int rc,
                           input int ofs, input bit ind, input int len, input string tag);
    int tx_bad = 0, rx_bad = 0, ind_bad = 0, tx_cnt = 0, tx_exp_cnt = 0;
    @(negedge clk);
    tx_slot = 6'(ts); tx_cap = 8'(tc); rx_slot = 6'(rs); rx_cap = 8'(rc);
    bit_ofs = 3'(ofs); ind_en = ind; fsync = 1'b1;
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      fsync = 1'b0;
      begin
        bit et = in_win(p, ts, tc, ofs);
        bit er = in_win(p, rs, rc, ofs);
        bit ei = !(ind && et);
        if (tx_en != et) tx_bad++;
        if (rx_en != er) rx_bad++;
        if (tx_ind_n != ei) ind_bad++;
        if (tx_en) tx_cnt++;
        if (et) tx_exp_cnt++;
      end
    end
    check(tx_bad == 0, {tag, " R2 R10 tx mismatches"}, tx_bad, 0);
    check(rx_bad == 0, {tag, " R4 rx mismatches"}, rx_bad, 0);
    check(ind_bad == 0, {tag, " R5 R6 indicator mismatches"}, ind_bad, 0);
    check(tx_cnt == tx_exp_cnt, {tag, " R3 tx width"}, tx_cnt, tx_exp_cnt);
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_en || rx_en || !tx_ind_n) bad++;
    end
    check(bad == 0, "R9 idle before first sync", bad, 0);
  endtask

  task automatic t_basic();
    run_frame(2, 7, 5, 15, 0, 1'b1, 80, "basic");
    run_frame(10, 0, 3, 31, 5, 1'b1, 120, "single-bit tx R3");
    run_frame(0, 255, 1, 0, 0, 1'b1, 300, "full-width tx at zero");
  endtask

  task automatic t_indicator_off();
    run_frame(4, 20, 4, 20, 2, 1'b0, 80, "R6 indicator off");
  endtask

  task automatic t_truncate();
    run_frame(63, 255, 60, 255, 7, 1'b1, 600, "R7 truncation at 511");
  endtask

  task automatic t_early_sync();
    run_frame(2, 100, 3, 100, 0, 1'b1, 40, "R8 before early sync");
    @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    check(tx_en == 1'b0, "R8 tx closes on early sync", int'(tx_en), 0);
    check(tx_ind_n == 1'b1, "R8 indicator releases on early sync", int'(tx_ind_n), 1);
    check(rx_en == 1'b0, "R8 rx closes on early sync", int'(rx_en), 0);
    run_frame(2, 100, 3, 100, 0, 1'b1, 150, "R1 R8 after early sync");
  endtask

  initial begin
    #(150000 * 10);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(tx_en == 1'b0 && rx_en == 1'b0 && tx_ind_n == 1'b1, "R9 reset state",
          int'({tx_en, rx_en, tx_ind_n}), 1);
    t_reset();
    t_basic();
    t_indicator_off();
    t_truncate();
    t_early_sync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule